// File: doc/BRIEF.md
# Sixteen-bit Compare Timer with Forced Output Events

This block is a 16-bit up-counter with three output-compare channels (A, B, C). Software reaches it through an 8-bit register bus. The counter advances on one of three sources: a prescaled tick from outside the block, a rising edge on an external pin, or a falling edge on that pin. The external pin is synchronized before its edges are detected. Each channel compares its 16-bit value with the counter. On a match the channel sets its own interrupt flag and drives its waveform pin according to a 2-bit action setting. In clear-on-A mode, a match on channel A returns the counter to zero.

Sixteen-bit values cross the 8-bit bus through one temporary byte. That byte is shared by the counter and all three compare registers, so both halves of a value move together. Software can also fire a channel's action at once through a strobe register. A strobe changes only the waveform pin. It sets no flag and never clears the counter. Two mode values stand for pulse-width modes. In those modes the waveform pins are frozen and the strobes do nothing.

A write to the counter masks compare matches for the next counting tick, so a freshly loaded value that equals a compare value does not fire a match.

Top module: `tmr_core`

## Requirements
- R1: 16-bit access uses a single temporary byte shared by the counter and all compare registers. Writing a high-byte address (counter 0x5, compare A/B/C 0x7/0x9/0xB) loads only that byte. Writing the matching low-byte address (0x4, 0x6, 0x8, 0xA) loads {temporary byte, written byte} in that cycle. Reading a low-byte address returns the low byte and copies the high byte into the temporary byte. Reading a high-byte address returns the temporary byte.
- R2: The control register at 0x0 holds the mode in bits 1:0 and the clock source in bits 3:2. Clock source 00 means stopped, 01 means tick_in, 10 means rising edges of ext_pin and 11 means falling edges of ext_pin. Each selected event advances the counter by one, and events from sources that are not selected have no effect.
- R3: A qualifying ext_pin edge is synchronized through two flops and advances the counter once, no more than three clock cycles after the edge.
- R4: On a counting tick where the counter equals compare X, the flag register at 0xC sets its bit for that channel (bit 0 is A, bit 1 is B, bit 2 is C). Writing a one to a flag bit clears it.
- R5: In mode 01 (clear-on-A), a tick that matches channel A loads the counter with zero instead of incrementing it.
- R6: A write to the counter masks compare matches on all channels for the next counting tick. The counter still increments on that tick.
- R7: The action register at 0x1 holds a 2-bit action per channel: A in bits 1:0, B in bits 3:2 and C in bits 5:4. Action 00 leaves the pin unchanged, 01 toggles it, 10 drives it low and 11 drives it high. In modes 00 and 01 a compare match applies the channel's action to its wave_out bit.
- R8: Writing the strobe register at 0x2 with bit 7 (A), bit 6 (B) or bit 5 (C) set applies that channel's action to its wave_out bit on the same clock edge. This holds in modes 00 and 01.
- R9: A strobe never sets a flag and never changes the counter, even in clear-on-A mode when the counter equals compare A.
- R10: The strobe register always reads as zero.
- R11: In modes 10 and 11, wave_out holds its value, and strobes and matches leave it unchanged. Matches still set flags, and the counter does not clear on a match with A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable (drives temporary-byte capture) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tick_in | input | 1 | Prescaled counting tick |
| ext_pin | input | 1 | Asynchronous external count input |
| wave_out | output | 3 | Waveform pins, bit 0 is channel A |
| irq_flag | output | 3 | Compare flags, bit 0 is channel A |

## Verification
The hardest case to reach is a tick that is masked because the counter was just written. The masking is only visible when the written value already equals a compare value. The stimulus loads the counter with exactly compare B and issues one tick, then confirms that no flag appears. It repeats the test with the value one below compare B, where the match must appear on the second tick. A second hard case is a channel whose compare value is zero, met on the first tick after a counter reload in clear-on-A mode. The masked match must stay silent there, while the same value one wrap later must fire. Strobes are checked with the counter parked on compare A, so that any wrongful clear or flag would be visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W   = 8;
    localparam int CNT_W   = 2 * BUS_W;
    localparam int N_CH    = 3;
    localparam int ADDR_W  = 4;
    localparam int SYNC_N  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_ACTION = 4'h1;
    localparam logic [ADDR_W-1:0] A_STROBE = 4'h2;
    localparam logic [ADDR_W-1:0] A_CNT_L  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CNT_H  = 4'h5;
    localparam int                A_CMP0   = 6;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'hC;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_CLR_ON_A = 2'b01,
        MODE_PWM_LO   = 2'b10,
        MODE_PWM_HI   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        SRC_OFF      = 2'b00,
        SRC_TICK     = 2'b01,
        SRC_EXT_RISE = 2'b10,
        SRC_EXT_FALL = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    typedef struct packed {
        src_e  src;
        mode_e mode;
    } ctrl_t;

    function automatic logic is_pwm(mode_e m);
        return m[1];
    endfunction

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_lo(int ch);
        return ADDR_W'(A_CMP0 + 2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_hi(int ch);
        return ADDR_W'(A_CMP0 + 2 * ch + 1);
    endfunction

endpackage

// File: rtl/tmr_clk_src.sv
module tmr_clk_src
    import tmr_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic tick_in,
    input  logic ext_pin,
    output logic tick
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              pin_s;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign pin_s = sync_q[STAGES-1];
    assign rise  = pin_s & ~prev_q;
    assign fall  = ~pin_s & prev_q;

    always_comb begin
        case (src)
            SRC_TICK:     tick = tick_in;
            SRC_EXT_RISE: tick = rise;
            SRC_EXT_FALL: tick = fall;
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
    import tmr_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int CW = CNT_W,
    parameter int NC = N_CH,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [AW-1:0]         addr,
    input  logic [BW-1:0]         wdata,
    output logic [BW-1:0]         rdata,
    input  logic [CW-1:0]         cnt,
    input  logic [NC-1:0]         flags,
    output ctrl_t                 ctrl,
    output logic [NC-1:0][1:0]    act_sel,
    output logic [NC-1:0][CW-1:0] cmp_val,
    output logic [NC-1:0]         strobe,
    output logic [NC-1:0]         flag_clr,
    output logic                  cnt_wr,
    output logic [CW-1:0]         cnt_wdata
);

    localparam int ACT_W = 2 * NC;

    ctrl_t            ctrl_q;
    logic [ACT_W-1:0] act_q;
    logic [BW-1:0]    temp_q;
    logic [BW-1:0]    temp_d;
    logic [CW-1:0]    cmp_q [NC];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            act_q  <= '0;
            temp_q <= '0;
            for (int c = 0; c < NC; c++) cmp_q[c] <= '0;
        end else begin
            temp_q <= temp_d;
            if (wr && addr == A_CTRL)   ctrl_q <= ctrl_t'(wdata[3:0]);
            if (wr && addr == A_ACTION) act_q  <= wdata[ACT_W-1:0];
            for (int c = 0; c < NC; c++) begin
                if (wr && addr == cmp_lo(c)) cmp_q[c] <= {temp_q, wdata};
            end
        end
    end

    always_comb begin
        temp_d = temp_q;
        if (rd) begin
            if (addr == A_CNT_L) temp_d = cnt[CW-1:BW];
            for (int c = 0; c < NC; c++) begin
                if (addr == cmp_lo(c)) temp_d = cmp_q[c][CW-1:BW];
            end
        end
        if (wr) begin
            if (addr == A_CNT_H) temp_d = wdata;
            for (int c = 0; c < NC; c++) begin
                if (addr == cmp_hi(c)) temp_d = wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = BW'(ctrl_q);
            A_ACTION: rdata = BW'(act_q);
            A_CNT_L:  rdata = cnt[BW-1:0];
            A_CNT_H:  rdata = temp_q;
            A_FLAGS:  rdata = BW'(flags);
            default:  rdata = '0;
        endcase
        for (int c = 0; c < NC; c++) begin
            if (addr == cmp_lo(c)) rdata = cmp_q[c][BW-1:0];
            if (addr == cmp_hi(c)) rdata = temp_q;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_ch
        assign act_sel[c]  = act_q[2*c +: 2];
        assign cmp_val[c]  = cmp_q[c];
        assign strobe[c]   = wr && (addr == A_STROBE) && wdata[BW-1-c];
        assign flag_clr[c] = wr && (addr == A_FLAGS) && wdata[c];
    end

    assign ctrl      = ctrl_q;
    assign cnt_wr    = wr && (addr == A_CNT_L);
    assign cnt_wdata = {temp_q, wdata};

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          hold,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [1:0]    act,
    input  logic          wave_en,
    input  logic          strobe,
    input  logic          flag_clr,
    output logic          match,
    output logic          wave,
    output logic          flag
);

    assign match = tick && !hold && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (wave_en && (strobe || match)) wave <= apply_act(act_e'(act), wave);
            if (match)         flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int CW = CNT_W,
    parameter int NC = N_CH,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          tick_in,
    input  logic          ext_pin,
    output logic [NC-1:0] wave_out,
    output logic [NC-1:0] irq_flag
);

    ctrl_t                 ctrl;
    mode_e                 cur_mode;
    logic [NC-1:0][1:0]    act_sel;
    logic [NC-1:0][CW-1:0] cmp_val;
    logic [NC-1:0]         strobe;
    logic [NC-1:0]         flag_clr;
    logic [NC-1:0]         match;
    logic                  cnt_wr;
    logic [CW-1:0]         cnt_wdata;
    logic [CW-1:0]         count_q;
    logic                  hold_q;
    logic                  timer_tick;
    logic                  wave_en;

    assign cur_mode = ctrl.mode;
    assign wave_en  = !is_pwm(cur_mode);

    tmr_clk_src #(.STAGES(SYNC_N)) u_src (
        .clk     (clk),
        .rst     (rst),
        .src     (ctrl.src),
        .tick_in (tick_in),
        .ext_pin (ext_pin),
        .tick    (timer_tick)
    );

    tmr_regbus #(.BW(BW), .CW(CW), .NC(NC), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .cnt       (count_q),
        .flags     (irq_flag),
        .ctrl      (ctrl),
        .act_sel   (act_sel),
        .cmp_val   (cmp_val),
        .strobe    (strobe),
        .flag_clr  (flag_clr),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata)
    );

    for (genvar c = 0; c < NC; c++) begin : g_chan
        tmr_cmp_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (timer_tick),
            .hold     (hold_q),
            .cnt      (count_q),
            .cmp      (cmp_val[c]),
            .act      (act_sel[c]),
            .wave_en  (wave_en),
            .strobe   (strobe[c]),
            .flag_clr (flag_clr[c]),
            .match    (match[c]),
            .wave     (wave_out[c]),
            .flag     (irq_flag[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            hold_q  <= 1'b0;
        end else if (cnt_wr) begin
            count_q <= cnt_wdata;
            hold_q  <= 1'b1;
        end else if (timer_tick) begin
            hold_q  <= 1'b0;
            if (cur_mode == MODE_CLR_ON_A && match[0]) count_q <= '0;
            else                                      count_q <= count_q + CW'(1);
        end
    end

endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
    import tmr_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int CW = CNT_W,
    parameter int NC = N_CH,
    parameter int AW = ADDR_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_rd,
    input logic [AW-1:0]         bus_addr,
    input logic [BW-1:0]         bus_rdata,
    input logic [NC-1:0]         wave_out,
    input logic [NC-1:0]         irq_flag,
    input logic                  timer_tick,
    input logic                  hold_q,
    input logic [CW-1:0]         count_q,
    input logic [NC-1:0][CW-1:0] cmp_val,
    input logic                  cnt_wr,
    input logic [CW-1:0]         cnt_wdata,
    input mode_e                 cur_mode
);

    // R10
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STROBE) |-> (bus_rdata == '0));

    // R1
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count_q == $past(cnt_wdata)));

    // R5
    clear_on_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_CLR_ON_A && timer_tick && !hold_q && !cnt_wr
         && count_q == cmp_val[0]) |=> (count_q == '0));

    // R11
    pwm_wave_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        is_pwm(cur_mode) |=> $stable(wave_out));

    for (genvar c = 0; c < NC; c++) begin : g_flag
        // R9 and R6: a flag only rises after an unmasked tick that matched
        flag_source_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_flag[c]) |-> $past(timer_tick && !hold_q && count_q == cmp_val[c]));
    end

endmodule

bind tmr_core tmr_core_chk #(.BW(BW), .CW(CW), .NC(NC), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .wave_out   (wave_out),
    .irq_flag   (irq_flag),
    .timer_tick (timer_tick),
    .hold_q     (hold_q),
    .count_q    (count_q),
    .cmp_val    (cmp_val),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cur_mode   (cur_mode)
);

// File: tb/tmr_core_tb.sv
module tmr_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_in = 1'b0;
    logic       ext_pin = 1'b0;
    logic [2:0] wave_out;
    logic [2:0] irq_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] exp_v;
    string      exp_t;

    always #10 clk = ~clk;

    tmr_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_in   (tick_in),
        .ext_pin   (ext_pin),
        .wave_out  (wave_out),
        .irq_flag  (irq_flag)
    );

    // monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected read addr %0h actual %02h expected none",
                         bus_addr, bus_rdata);
            end else begin
                exp_v = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                if (bus_rdata !== exp_v) begin
                    n_fail++;
                    $display("FAIL %s: addr %0h actual %02h expected %02h",
                             exp_t, bus_addr, bus_rdata, exp_v);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick_in = 1'b1;
            @(posedge clk); #1; tick_in = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic chk_wave(input logic [2:0] e, input string tag);
        @(negedge clk);
        n_chk++;
        if (wave_out !== e) begin
            n_fail++;
            $display("FAIL %s: wave_out actual %b expected %b", tag, wave_out, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // reset state
        rd(4'h0, 8'h00, "R2 reset ctrl");
        rd(4'h4, 8'h00, "R1 reset counter");
        rd(4'hC, 8'h00, "R4 reset flags");
        chk_wave(3'b000, "R7 reset wave");

        // 16-bit access through the temporary byte
        wr(4'h5, 8'h12);
        wr(4'h4, 8'h34);
        rd(4'h4, 8'h34, "R1 counter low");
        rd(4'h5, 8'h12, "R1 counter high");
        ticks(2);
        rd(4'h4, 8'h34, "R2 stopped source ignores tick");
        wr(4'h7, 8'h56);
        rd(4'h5, 8'h56, "R1 shared temporary byte");
        wr(4'h6, 8'h00);
        rd(4'h6, 8'h00, "R1 compare A low");
        rd(4'h7, 8'h56, "R1 compare A high");

        // counting on the prescaled tick
        wr(4'h0, 8'h04);
        wr(4'h5, 8'h00);
        wr(4'h4, 8'hFE);
        ticks(3);
        rd(4'h4, 8'h01, "R2 count low");
        rd(4'h5, 8'h01, "R2 count carry");

        // compare B match sets flag
        wr(4'h9, 8'h01);
        wr(4'h8, 8'h05);
        ticks(4);
        rd(4'hC, 8'h00, "R4 no flag before match");
        ticks(1);
        rd(4'hC, 8'h02, "R4 flag B on match");
        rd(4'h4, 8'h06, "R2 count past match");
        wr(4'hC, 8'h02);
        rd(4'hC, 8'h00, "R4 write one clears");

        // counter write masks the next tick
        wr(4'h5, 8'h01);
        wr(4'h4, 8'h05);
        ticks(1);
        rd(4'hC, 8'h00, "R6 masked match");
        rd(4'h4, 8'h06, "R6 count still increments");
        wr(4'h5, 8'h01);
        wr(4'h4, 8'h04);
        ticks(2);
        rd(4'hC, 8'h02, "R6 match after mask tick");
        wr(4'hC, 8'h07);

        // clear-on-A mode with toggle on A, set on C
        wr(4'h1, 8'h39);
        wr(4'h0, 8'h05);
        wr(4'h7, 8'h00);
        wr(4'h6, 8'h03);
        wr(4'h5, 8'h00);
        wr(4'h4, 8'h00);
        ticks(3);
        rd(4'h4, 8'h03, "R5 count to top");
        rd(4'hC, 8'h00, "R6 zero compare C masked");
        ticks(1);
        rd(4'h4, 8'h00, "R5 cleared on A");
        rd(4'hC, 8'h01, "R5 flag A");
        chk_wave(3'b001, "R7 toggle on A match");
        wr(4'hC, 8'h07);
        ticks(1);
        rd(4'hC, 8'h04, "R4 flag C on zero");
        chk_wave(3'b101, "R7 set on C match");

        // strobes, counter parked on compare A
        wr(4'h0, 8'h01);
        wr(4'hC, 8'h07);
        wr(4'h5, 8'h00);
        wr(4'h4, 8'h03);
        wr(4'h1, 8'h29);
        wr(4'h2, 8'h20);
        chk_wave(3'b001, "R8 strobe C clear");
        wr(4'h2, 8'h80);
        chk_wave(3'b000, "R8 strobe A toggle");
        rd(4'h4, 8'h03, "R9 strobe keeps counter");
        rd(4'hC, 8'h00, "R9 strobe sets no flag");
        wr(4'h1, 8'h25);
        wr(4'h2, 8'h40);
        chk_wave(3'b010, "R8 strobe B toggle");
        rd(4'h2, 8'h00, "R10 strobe reads zero");
        wr(4'h1, 8'h00);
        wr(4'h2, 8'hE0);
        chk_wave(3'b010, "R7 action none");

        // pulse-width mode values
        wr(4'h0, 8'h02);
        wr(4'h1, 8'h15);
        wr(4'h2, 8'hE0);
        chk_wave(3'b010, "R11 strobe ignored");
        wr(4'h0, 8'h06);
        wr(4'h5, 8'h00);
        wr(4'h4, 8'h02);
        ticks(2);
        chk_wave(3'b010, "R11 match leaves wave");
        rd(4'hC, 8'h01, "R11 match still flags");
        rd(4'h4, 8'h04, "R11 no clear on A");
        wr(4'hC, 8'h07);

        // external pin, rising then falling
        wr(4'h0, 8'h08);
        wr(4'h5, 8'h00);
        wr(4'h4, 8'h00);
        ext_pin = 1'b1;
        idle(4);
        rd(4'h4, 8'h01, "R3 rising edge counts");
        ext_pin = 1'b0;
        idle(4);
        rd(4'h4, 8'h01, "R3 falling ignored");
        ticks(2);
        rd(4'h4, 8'h01, "R2 tick ignored on ext");
        wr(4'h0, 8'h0C);
        ext_pin = 1'b1;
        idle(4);
        rd(4'h4, 8'h01, "R3 rising ignored");
        ext_pin = 1'b0;
        idle(4);
        rd(4'h4, 8'h02, "R3 falling edge counts");

        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule